// File: doc/BRIEF.md
# CAN Bus-Off Recovery Controller

This block tracks the fault-confinement state of a CAN node and decides how the node comes back from bus-off. It reads the transmit and receive error counts kept elsewhere and a per-bit strobe from the bit-timing logic. The strobe says whether the sampled bit was recessive. From these it reports one of four states: error-active, error-passive, bus-off or halt. It also drives a communication-enable line, a one-cycle strobe that tells the counter logic to zero both error counts, and a sticky flag that records a completed recovery.

A two-bit policy input picks one of four recovery policies. The policy is captured when bus-off begins and is held until bus-off ends, so a later change to the input has no effect until then. Software can also end bus-off at once with a forced-return pulse. It can move the node to halt with a halt request, which only the software-halt policy honours. It can leave halt with a resume pulse. Each exit path has its own rule for whether the recovery flag is raised.

All outputs are registered. An input sampled at one rising edge shows up on the outputs from that edge onward.

Top module: `can_busoff_ctrl`

## Requirements
- R1: `fc_state` encodes 00 error-active, 01 error-passive, 10 bus-off and 11 halt. Outside bus-off and halt, the state is error-passive when either count exceeds PASSIVE_LIM (127) and error-active otherwise. A transmit count above BUSOFF_LIM (255) starts bus-off.
- R2: During bus-off `comm_en` is 0 and the error-count inputs are ignored. The policy in force is the value `policy_sel` had at bus-off entry, and later changes to it are ignored until bus-off ends.
- R3: Recovery completes on the bit that finishes the RECOV_OCC-th run of RUN_LEN consecutive recessive bits, where only bits with `bit_vld` high are counted. A dominant bit restarts the current run but keeps the runs already completed.
- R4: Policy 00: when recovery completes, the state becomes error-active, `comm_en` becomes 1 and `recov_flag` is set, all in the same cycle.
- R5: Policy 01: a transmit count above the limit sends the node straight to halt, with `comm_en` 0 and `recov_flag` unchanged.
- R6: Policy 10: when recovery completes, the state becomes halt and `recov_flag` is set.
- R7: Policy 11: `halt_req` during bus-off moves the node to halt without setting the flag. Outside bus-off, `halt_req` is ignored. Without a request, recovery behaves as in R4.
- R8: `force_ret` during bus-off moves the node to error-active in the next cycle, with `comm_en` 0 and the flag unchanged. The recessive run restarts, and `comm_en` rises on the bit that completes RUN_LEN consecutive recessive bits.
- R9: `err_cnt_clr` pulses for exactly one cycle, together with the state change, on every exit from bus-off and on a direct entry to halt under policy 01.
- R10: `recov_flag` stays set until `flag_clr` is asserted. A set in the same cycle as a clear wins.
- R11: Halt is left only through `resume_req`, which moves the node to error-active with `comm_en` 0. `comm_en` then rises on the bit that completes RUN_LEN consecutive recessive bits.
- R12: After reset the state is error-active, `comm_en` is 1, `recov_flag` is 0 and `err_cnt_clr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_sel | input | 2 | Recovery policy: 00 auto, 01 halt at entry, 10 halt at end, 11 halt on request |
| force_ret | input | 1 | One-cycle forced return from bus-off |
| halt_req | input | 1 | One-cycle software halt request |
| resume_req | input | 1 | One-cycle software write back to normal operation |
| tx_err_cnt | input | CNT_W | Transmit error count |
| rx_err_cnt | input | CNT_W | Receive error count |
| bit_vld | input | 1 | Strobe marking one sampled bus bit |
| bit_rec | input | 1 | Sampled bit was recessive (valid with bit_vld) |
| flag_clr | input | 1 | Software clear of the recovery flag |
| fc_state | output | 2 | Fault-confinement state |
| comm_en | output | 1 | Communication enabled |
| err_cnt_clr | output | 1 | One-cycle request to zero both error counts |
| recov_flag | output | 1 | Sticky recovery-detected flag |

## Verification
The bench builds the block with RUN_LEN at 11 and RECOV_OCC lowered to 4. A full bus-off recovery therefore takes 44 strobed bits instead of 1408, so every policy, the forced return, and a policy change in the middle of bus-off can all be driven to completion in one short run. The counter widths keep their defaults of 9 bits, so the limits 127 and 255 are tested on both sides. Dominant bits are placed inside a run, both before recovery and after a forced return, to show that a run restarts while completed runs are kept.

// File: rtl/can_boff_pkg.sv
package can_boff_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10,
    FC_HALT    = 2'b11
  } fc_state_e;

  localparam logic [1:0] POL_AUTO       = 2'b00;
  localparam logic [1:0] POL_HALT_ENTRY = 2'b01;
  localparam logic [1:0] POL_HALT_END   = 2'b10;
  localparam logic [1:0] POL_HALT_SW    = 2'b11;
endpackage

// File: rtl/can_boff_run_cnt.sv
module can_boff_run_cnt #(
  parameter int RUN_LEN   = 11,
  parameter int RECOV_OCC = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic clr_i,
  input  logic bit_vld_i,
  input  logic bit_rec_i,
  output logic run_done_o,
  output logic recov_done_o
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam int OCC_W = $clog2(RECOV_OCC + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [OCC_W-1:0] OCC_LAST = OCC_W'(RECOV_OCC - 1);

  logic [RUN_W-1:0] run_q;
  logic [OCC_W-1:0] occ_q;
  logic             run_last;

  assign run_last     = (run_q == RUN_LAST);
  assign run_done_o   = en_i & bit_vld_i & bit_rec_i & run_last;
  assign recov_done_o = run_done_o & (occ_q == OCC_LAST);

  always_ff @(posedge clk) begin
    if (rst || !en_i || clr_i) begin
      run_q <= '0;
      occ_q <= '0;
    end else if (bit_vld_i) begin
      if (!bit_rec_i) begin
        run_q <= '0;
      end else if (run_last) begin
        run_q <= '0;
        occ_q <= (occ_q == OCC_LAST) ? '0 : occ_q + 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R3
  run_range_chk: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_LAST);
  // R3
  dominant_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && !clr_i && bit_vld_i && !bit_rec_i) |=> (run_q == '0));
endmodule

// File: rtl/can_boff_flag.sv
module can_boff_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q);
  // R10
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_q);
  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/can_boff_fsm.sv
module can_boff_fsm
  import can_boff_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int PASSIVE_LIM = 127,
  parameter int BUSOFF_LIM  = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       policy_i,
  input  logic             force_ret_i,
  input  logic             halt_req_i,
  input  logic             resume_req_i,
  input  logic [CNT_W-1:0] tec_i,
  input  logic [CNT_W-1:0] rec_i,
  input  logic             run_done_i,
  input  logic             recov_done_i,
  output logic [1:0]       state_o,
  output logic             comm_en_o,
  output logic             cnt_en_o,
  output logic             cnt_clr_o,
  output logic             flag_set_o,
  output logic             err_clr_o
);
  localparam logic [CNT_W-1:0] P_LIM = CNT_W'(PASSIVE_LIM);
  localparam logic [CNT_W-1:0] B_LIM = CNT_W'(BUSOFF_LIM);

  fc_state_e  st_q, st_n;
  logic       comm_q, comm_n;
  logic       wait_q, wait_n;
  logic       eclr_q, eclr_n;
  logic [1:0] pol_q;

  always_comb begin
    st_n       = st_q;
    comm_n     = comm_q;
    wait_n     = wait_q;
    eclr_n     = 1'b0;
    flag_set_o = 1'b0;
    cnt_clr_o  = 1'b0;
    unique case (st_q)
      FC_BUSOFF: begin
        if (force_ret_i) begin
          st_n      = FC_ACTIVE;
          comm_n    = 1'b0;
          wait_n    = 1'b1;
          eclr_n    = 1'b1;
          cnt_clr_o = 1'b1;
        end else if (pol_q == POL_HALT_SW && halt_req_i) begin
          st_n   = FC_HALT;
          wait_n = 1'b0;
          eclr_n = 1'b1;
        end else if (recov_done_i) begin
          flag_set_o = 1'b1;
          eclr_n     = 1'b1;
          if (pol_q == POL_HALT_END) begin
            st_n = FC_HALT;
          end else begin
            st_n   = FC_ACTIVE;
            comm_n = 1'b1;
          end
        end
      end
      FC_HALT: begin
        if (resume_req_i) begin
          st_n      = FC_ACTIVE;
          comm_n    = 1'b0;
          wait_n    = 1'b1;
          cnt_clr_o = 1'b1;
        end
      end
      default: begin
        if (tec_i > B_LIM) begin
          comm_n = 1'b0;
          wait_n = 1'b0;
          if (policy_i == POL_HALT_ENTRY) begin
            st_n   = FC_HALT;
            eclr_n = 1'b1;
          end else begin
            st_n = FC_BUSOFF;
          end
        end else begin
          st_n = (tec_i > P_LIM || rec_i > P_LIM) ? FC_PASSIVE : FC_ACTIVE;
          if (wait_q && run_done_i) begin
            comm_n = 1'b1;
            wait_n = 1'b0;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= FC_ACTIVE;
      comm_q <= 1'b1;
      wait_q <= 1'b0;
      eclr_q <= 1'b0;
      pol_q  <= POL_AUTO;
    end else begin
      st_q   <= st_n;
      comm_q <= comm_n;
      wait_q <= wait_n;
      eclr_q <= eclr_n;
      if (st_q != FC_BUSOFF) pol_q <= policy_i;
    end
  end

  assign state_o   = st_q;
  assign comm_en_o = comm_q;
  assign err_clr_o = eclr_q;
  assign cnt_en_o  = (st_q == FC_BUSOFF) | wait_q;

  // R2
  busoff_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == FC_BUSOFF) |-> !comm_q);
  // R2
  policy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == FC_BUSOFF && $past(st_q) == FC_BUSOFF) |-> $stable(pol_q));
  // R5
  entry_policy_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == FC_BUSOFF) |-> (pol_q != POL_HALT_ENTRY));
  // R9
  clr_on_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q != FC_BUSOFF && $past(st_q) == FC_BUSOFF) |-> eclr_q);
  // R9
  clr_single_chk: assert property (@(posedge clk) disable iff (rst)
    eclr_q |=> !eclr_q);
  // R11
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == FC_HALT && !resume_req_i) |=> (st_q == FC_HALT));
  // R11
  halt_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == FC_HALT) |-> !comm_q);
endmodule

// File: rtl/can_busoff_ctrl.sv
module can_busoff_ctrl #(
  parameter int CNT_W       = 9,
  parameter int PASSIVE_LIM = 127,
  parameter int BUSOFF_LIM  = 255,
  parameter int RUN_LEN     = 11,
  parameter int RECOV_OCC   = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       policy_sel,
  input  logic             force_ret,
  input  logic             halt_req,
  input  logic             resume_req,
  input  logic [CNT_W-1:0] tx_err_cnt,
  input  logic [CNT_W-1:0] rx_err_cnt,
  input  logic             bit_vld,
  input  logic             bit_rec,
  input  logic             flag_clr,
  output logic [1:0]       fc_state,
  output logic             comm_en,
  output logic             err_cnt_clr,
  output logic             recov_flag
);
  logic cnt_en, cnt_clr, run_done, recov_done, flag_set;

  can_boff_run_cnt #(
    .RUN_LEN   (RUN_LEN),
    .RECOV_OCC (RECOV_OCC)
  ) u_run (
    .clk          (clk),
    .rst          (rst),
    .en_i         (cnt_en),
    .clr_i        (cnt_clr),
    .bit_vld_i    (bit_vld),
    .bit_rec_i    (bit_rec),
    .run_done_o   (run_done),
    .recov_done_o (recov_done)
  );

  can_boff_fsm #(
    .CNT_W       (CNT_W),
    .PASSIVE_LIM (PASSIVE_LIM),
    .BUSOFF_LIM  (BUSOFF_LIM)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .policy_i     (policy_sel),
    .force_ret_i  (force_ret),
    .halt_req_i   (halt_req),
    .resume_req_i (resume_req),
    .tec_i        (tx_err_cnt),
    .rec_i        (rx_err_cnt),
    .run_done_i   (run_done),
    .recov_done_i (recov_done),
    .state_o      (fc_state),
    .comm_en_o    (comm_en),
    .cnt_en_o     (cnt_en),
    .cnt_clr_o    (cnt_clr),
    .flag_set_o   (flag_set),
    .err_clr_o    (err_cnt_clr)
  );

  can_boff_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (recov_flag)
  );
endmodule

// File: tb/can_busoff_ctrl_bench.sv
module can_busoff_ctrl_bench;
  localparam int CNT_W = 9;
  localparam logic [1:0] ACT = 2'b00, PAS = 2'b01, BOF = 2'b10, HLT = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] policy_sel = 2'b00;
  logic force_ret = 0, halt_req = 0, resume_req = 0;
  logic [CNT_W-1:0] tx_err_cnt = '0, rx_err_cnt = '0;
  logic bit_vld = 0, bit_rec = 0, flag_clr = 0;
  logic [1:0] fc_state;
  logic comm_en, err_cnt_clr, recov_flag;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  logic [4:0] exp_q[$];
  string req_q[$];

  always #10 clk = ~clk;

  can_busoff_ctrl #(
    .CNT_W(CNT_W), .PASSIVE_LIM(127), .BUSOFF_LIM(255),
    .RUN_LEN(11), .RECOV_OCC(4)
  ) u_can_busoff_ctrl (
    .clk(clk), .rst(rst), .policy_sel(policy_sel), .force_ret(force_ret),
    .halt_req(halt_req), .resume_req(resume_req), .tx_err_cnt(tx_err_cnt),
    .rx_err_cnt(rx_err_cnt), .bit_vld(bit_vld), .bit_rec(bit_rec),
    .flag_clr(flag_clr), .fc_state(fc_state), .comm_en(comm_en),
    .err_cnt_clr(err_cnt_clr), .recov_flag(recov_flag)
  );

  // monitor: pops one expectation per falling edge and compares
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      logic [4:0] a;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      a = {fc_state, comm_en, recov_flag, err_cnt_clr};
      vectors++;
      if (a !== e) begin
        miscompares++;
        $display("FAIL %s actual st=%b ce=%b fl=%b clr=%b expected st=%b ce=%b fl=%b clr=%b",
                 r, a[4:3], a[2], a[1], a[0], e[4:3], e[2], e[1], e[0]);
      end
    end
  end

  task automatic end_pulses();
    force_ret = 0; halt_req = 0; resume_req = 0; bit_vld = 0; flag_clr = 0;
  endtask

  // driver: apply current inputs over one edge, push the expected outputs
  task automatic expect_after(input logic [1:0] st, input logic ce, input logic fl,
                              input logic cl, input string req);
    @(posedge clk);
    exp_q.push_back({st, ce, fl, cl});
    req_q.push_back(req);
    @(negedge clk);
    end_pulses();
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
    end_pulses();
  endtask

  task automatic bits(input int n, input logic rec);
    for (int i = 0; i < n; i++) begin
      bit_vld = 1; bit_rec = rec;
      idle();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    expect_after(ACT, 1, 0, 0, "R12");

    // R1 thresholds
    rx_err_cnt = 128; expect_after(PAS, 1, 0, 0, "R1");
    rx_err_cnt = 127; expect_after(ACT, 1, 0, 0, "R1");
    tx_err_cnt = 200; expect_after(PAS, 1, 0, 0, "R1");
    tx_err_cnt = 255; expect_after(PAS, 1, 0, 0, "R1");
    tx_err_cnt = 256; expect_after(BOF, 0, 0, 0, "R1");
    // R2: counts and policy changes ignored during bus-off
    tx_err_cnt = 0; rx_err_cnt = 0; policy_sel = 2'b10;
    expect_after(BOF, 0, 0, 0, "R2");
    // R3: two runs, an interrupted run, one more run, then 10 of the last
    bits(22, 1); bits(10, 1); bits(1, 0); bits(11, 1); bits(9, 1);
    bit_vld = 1; bit_rec = 1; expect_after(BOF, 0, 0, 0, "R3");
    bit_vld = 1; bit_rec = 1; expect_after(ACT, 1, 1, 1, "R4 R2");
    expect_after(ACT, 1, 1, 0, "R9");
    expect_after(ACT, 1, 1, 0, "R10");
    flag_clr = 1; expect_after(ACT, 1, 0, 0, "R10");

    // policy 01
    policy_sel = 2'b01; tx_err_cnt = 256; expect_after(HLT, 0, 0, 1, "R5");
    tx_err_cnt = 0; expect_after(HLT, 0, 0, 0, "R9");
    bits(11, 1); expect_after(HLT, 0, 0, 0, "R11");
    resume_req = 1; expect_after(ACT, 0, 0, 0, "R11");
    bits(9, 1);
    bit_vld = 1; bit_rec = 1; expect_after(ACT, 0, 0, 0, "R11");
    bit_vld = 1; bit_rec = 1; expect_after(ACT, 1, 0, 0, "R11");

    // policy 10 with a clear in the completing cycle
    policy_sel = 2'b10; tx_err_cnt = 256; expect_after(BOF, 0, 0, 0, "R6");
    tx_err_cnt = 0; bits(43, 1);
    bit_vld = 1; bit_rec = 1; flag_clr = 1; expect_after(HLT, 0, 1, 1, "R6 R10");
    resume_req = 1; expect_after(ACT, 0, 1, 0, "R11");
    bits(10, 1);
    bit_vld = 1; bit_rec = 1; expect_after(ACT, 1, 1, 0, "R11");
    flag_clr = 1; expect_after(ACT, 1, 0, 0, "R10");

    // policy 11
    policy_sel = 2'b11; halt_req = 1; expect_after(ACT, 1, 0, 0, "R7");
    tx_err_cnt = 256; expect_after(BOF, 0, 0, 0, "R7");
    tx_err_cnt = 0; bits(5, 1);
    halt_req = 1; expect_after(HLT, 0, 0, 1, "R7");
    resume_req = 1; expect_after(ACT, 0, 0, 0, "R11");
    bits(11, 1); expect_after(ACT, 1, 0, 0, "R11");
    tx_err_cnt = 256; expect_after(BOF, 0, 0, 0, "R7");
    tx_err_cnt = 0; bits(43, 1);
    bit_vld = 1; bit_rec = 1; expect_after(ACT, 1, 1, 1, "R7");
    flag_clr = 1; expect_after(ACT, 1, 0, 0, "R10");

    // forced return
    policy_sel = 2'b00; tx_err_cnt = 256; expect_after(BOF, 0, 0, 0, "R8");
    tx_err_cnt = 0; bits(5, 1);
    force_ret = 1; expect_after(ACT, 0, 0, 1, "R8 R9");
    bits(5, 1);
    bit_vld = 1; bit_rec = 1; expect_after(ACT, 0, 0, 0, "R8");
    bits(1, 0); bits(10, 1);
    bit_vld = 1; bit_rec = 1; expect_after(ACT, 1, 0, 0, "R8");

    repeat (2) idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule